// File: doc/BRIEF.md
# Configurable SPI master

This block is a single-master synchronous serial controller. It drives a serial clock, a data output and one active-low select, and it reads a data input. A write on the local data port starts a full-duplex transfer whose character length can be set anywhere from 2 to 32 bits. One bit goes out and one bit comes in during each serial clock period. The serial clock is made from the system clock by a programmable divider. The clock's idle level and the edge used for sampling can be set separately, so all four SPI modes are available.

Around each character the block holds select low for a programmable number of system clocks before the first serial clock edge and after the last one. When select is released, a done flag is raised and the received character can be read, right-aligned. A write that arrives while a transfer is running is refused and sets a sticky collision flag. The transfer in progress is left untouched.

Top module: `spi_master`

## Requirements
- R1: While reset is held, spi_cs_n is 1, spi_sck is 0, and busy, done and collision are 0.
- R2: While idle, spi_sck rests at cfg_cpol. Each transfer makes exactly 2*len transitions of spi_sck, and each half period lasts cfg_div+1 system clocks. A leading edge is a transition away from cfg_cpol.
- R3: The character is sent most significant bit first and consists of the low len bits of wr_data (len = cfg_len, legal values 2 to 32). With cfg_cpha=0, spi_miso is sampled on leading edges and spi_mosi changes on trailing edges, and the first bit is on spi_mosi when select falls. With cfg_cpha=1, spi_mosi changes on leading edges and spi_miso is sampled on trailing edges.
- R4: After a transfer, rd_data holds the len received bits right-aligned, with the first bit received as the most significant of them, and every bit above them is 0.
- R5: spi_cs_n falls on the clock edge that accepts wr_en while idle. The first spi_sck transition comes cfg_setup+cfg_div+2 system clocks after that fall.
- R6: spi_cs_n rises cfg_hold+1 system clocks after the last spi_sck transition. busy is high from the accepting edge until that rise.
- R7: done rises on the same edge on which spi_cs_n rises. done clears on the edge after rd_en is sampled, or when a new write is accepted.
- R8: A wr_en sampled while busy sets collision on the next edge. It changes neither the transmitted nor the received character of the running transfer.
- R9: collision stays set until a clr_coll pulse clears it. A clr_coll pulse with no collision in the same cycle leaves it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_len | input | 6 | Character length in bits, 2 to 32 |
| cfg_div | input | 8 | Half period of spi_sck, in system clocks, minus one |
| cfg_setup | input | 8 | Select setup delay count |
| cfg_hold | input | 8 | Select hold delay count |
| wr_en | input | 1 | Write strobe: starts a transfer when idle |
| wr_data | input | 32 | Character to send, right-aligned |
| rd_en | input | 1 | Read strobe for the receive register; clears done |
| rd_data | output | 32 | Received character, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete flag |
| collision | output | 1 | Sticky write-collision flag |
| clr_coll | input | 1 | Write-one pulse that clears collision |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low select |

## Verification
The bench timestamps the fall of select, the first and last serial clock transitions and the rise of select. From these it checks that the setup interval is exactly cfg_setup+cfg_div+2 clocks and the hold interval is exactly cfg_hold+1 clocks. A slave model in the bench shifts on the edges that the mode selects. On a sampling edge spi_mosi is never being updated, so the captured value does not depend on the order of processes. The model changes spi_miso just after a change edge, at least one half period before the design samples it. Flags are read at the falling clock edge that follows the edge which should have changed them: collision one edge after the refused write, done on the edge where select rises, and the cleared done one edge after rd_en.

// File: rtl/spi_pkg.sv
package spi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_XFER  = 2'd2,
        ST_HOLD  = 2'd3
    } spi_state_e;
endpackage

// File: rtl/spi_tick.sv
// Half-period timer: pulses tick every div+1 clocks while enabled.
module spi_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] hc_d, hc_q;

    assign tick = en && (hc_q == div);

    always_comb begin
        hc_d = (!en || tick) ? '0 : hc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hc_q <= '0;
        else        hc_q <= hc_d;
    end
endmodule

// File: rtl/spi_align.sv
// Moves a right-aligned character of len bits to the top of the word.
module spi_align #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len,
    output logic [DATA_W-1:0] aligned
);
    logic [LEN_W:0] sh;

    always_comb begin
        sh      = (LEN_W+1)'(DATA_W) - {1'b0, len};
        aligned = data << sh;
    end
endmodule

// File: rtl/spi_flags.sv
// Done and collision flags; a set wins over a clear in the same cycle.
module spi_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done,
    input  logic clr_done,
    input  logic set_coll,
    input  logic clr_coll,
    output logic done,
    output logic coll
);
    typedef struct packed {
        logic done;
        logic coll;
    } flags_t;

    flags_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (clr_done) f_d.done = 1'b0;
        if (set_done) f_d.done = 1'b1;
        if (clr_coll) f_d.coll = 1'b0;
        if (set_coll) f_d.coll = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign done = f_q.done;
    assign coll = f_q.coll;
endmodule

// File: rtl/spi_master.sv
module spi_master #(
    parameter  int DATA_W = 32,
    parameter  int DIV_W  = 8,
    parameter  int DLY_W  = 8,
    localparam int LEN_W  = $clog2(DATA_W) + 1,
    localparam int EDGE_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DLY_W-1:0]  cfg_setup,
    input  logic [DLY_W-1:0]  cfg_hold,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              collision,
    input  logic              clr_coll,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    import spi_pkg::*;

    typedef struct packed {
        spi_state_e        st;
        logic [DLY_W-1:0]  cnt;
        logic [EDGE_W-1:0] ec;
        logic              sck;
        logic              mosi;
        logic              cs_n;
        logic              cpha;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } regs_t;

    regs_t r_d, r_q;

    logic              tick;
    logic              fin;
    logic              accept;
    logic              lead;
    logic [DATA_W-1:0] aligned;

    spi_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (r_q.st == ST_XFER),
        .div  (cfg_div),
        .tick (tick)
    );

    spi_align #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_align (
        .data   (wr_data),
        .len    (cfg_len),
        .aligned(aligned)
    );

    assign accept = wr_en && (r_q.st == ST_IDLE);

    spi_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_done(fin),
        .clr_done(rd_en || accept),
        .set_coll(wr_en && (r_q.st != ST_IDLE)),
        .clr_coll(clr_coll),
        .done    (done),
        .coll    (collision)
    );

    always_comb begin
        r_d  = r_q;
        fin  = 1'b0;
        lead = ~r_q.ec[0];
        case (r_q.st)
            ST_IDLE: begin
                r_d.sck  = cfg_cpol;
                r_d.cs_n = 1'b1;
                if (wr_en) begin
                    r_d.st   = ST_SETUP;
                    r_d.cnt  = '0;
                    r_d.ec   = '0;
                    r_d.cs_n = 1'b0;
                    r_d.cpha = cfg_cpha;
                    r_d.len  = cfg_len;
                    r_d.rx   = '0;
                    if (cfg_cpha) begin
                        r_d.mosi = 1'b0;
                        r_d.tx   = aligned;
                    end else begin
                        r_d.mosi = aligned[DATA_W-1];
                        r_d.tx   = aligned << 1;
                    end
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == cfg_setup) r_d.st  = ST_XFER;
                else                      r_d.cnt = r_q.cnt + 1'b1;
            end
            ST_XFER: begin
                if (tick) begin
                    r_d.sck = ~r_q.sck;
                    r_d.ec  = r_q.ec + EDGE_W'(1);
                    if (lead ^ r_q.cpha) begin
                        r_d.rx = {r_q.rx[DATA_W-2:0], spi_miso};
                    end else begin
                        r_d.mosi = r_q.tx[DATA_W-1];
                        r_d.tx   = r_q.tx << 1;
                    end
                    if (r_d.ec == {r_q.len, 1'b0}) begin
                        r_d.st  = ST_HOLD;
                        r_d.cnt = '0;
                    end
                end
            end
            default: begin
                if (r_q.cnt == cfg_hold) begin
                    r_d.st   = ST_IDLE;
                    r_d.cs_n = 1'b1;
                    fin      = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data  = r_q.rx;
    assign busy     = (r_q.st != ST_IDLE);
    assign spi_sck  = r_q.sck;
    assign spi_mosi = r_q.mosi;
    assign spi_cs_n = r_q.cs_n;
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic rd_en,
    input logic clr_coll,
    input logic busy,
    input logic done,
    input logic collision,
    input logic spi_cs_n
);
    assert_coll_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> collision);

    assert_coll_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_coll && !(busy && wr_en)) |=> !collision);

    assert_coll_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (collision && !clr_coll) |=> collision);

    assert_idle_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    assert_done_with_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $rose(spi_cs_n));

    assert_rd_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !busy) |=> !done);
endmodule

bind spi_master spi_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .clr_coll (clr_coll),
    .busy     (busy),
    .done     (done),
    .collision(collision),
    .spi_cs_n (spi_cs_n)
);

// File: tb/sim_spi_master.sv
`timescale 1ns/1ps
module sim_spi_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [5:0]  cfg_len = 6'd8;
    logic [7:0]  cfg_div = 8'd0, cfg_setup = 8'd0, cfg_hold = 8'd0;
    logic        wr_en = 1'b0, rd_en = 1'b0, clr_coll = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        busy, done, collision;
    logic        spi_sck, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;
    bit pending_done = 1'b0;

    // slave model state
    logic [31:0] sl_data = '0;
    logic [31:0] sl_rx = '0;
    int          sl_edges = 0;
    int          sl_pos = 0;
    int          cur_len = 8;
    time         t_csf = 0, t_first = 0, t_last = 0, t_csr = 0;

    always #10 clk = ~clk;

    spi_master u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_len(cfg_len), .cfg_div(cfg_div), .cfg_setup(cfg_setup),
        .cfg_hold(cfg_hold), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .busy(busy), .done(done), .collision(collision),
        .clr_coll(clr_coll), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge spi_cs_n) begin
        if (rst_n) begin
            t_csf    = $time;
            sl_edges = 0;
            sl_rx    = '0;
            sl_pos   = cur_len - 1;
            if (!cfg_cpha) spi_miso = sl_data[sl_pos];
        end
    end

    always @(posedge spi_cs_n) t_csr = $time;

    always @(spi_sck) begin
        if (rst_n && !spi_cs_n) begin
            if (sl_edges == 0) t_first = $time;
            t_last = $time;
            if ((spi_sck != cfg_cpol) ^ cfg_cpha) begin
                sl_rx = {sl_rx[30:0], spi_mosi};
            end else if (!cfg_cpha) begin
                sl_pos = sl_pos - 1;
                if (sl_pos >= 0) spi_miso = sl_data[sl_pos];
            end else begin
                if (sl_pos >= 0) spi_miso = sl_data[sl_pos];
                sl_pos = sl_pos - 1;
            end
            sl_edges++;
        end
    end

    task automatic run(input bit cpol, input bit cpha, input int len,
                       input int div, input int setup, input int hold,
                       input logic [31:0] txd, input logic [31:0] sld,
                       input bit do_coll, input bit skip_rd);
        logic [31:0] mask;
        int guard;
        mask = (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
        @(negedge clk);
        cfg_cpol  = cpol;
        cfg_cpha  = cpha;
        cfg_len   = 6'(len);
        cfg_div   = 8'(div);
        cfg_setup = 8'(setup);
        cfg_hold  = 8'(hold);
        cur_len   = len;
        sl_data   = sld;
        repeat (2) @(negedge clk);
        check("R2", "idle sck level", {31'd0, spi_sck}, {31'd0, cpol});
        wr_en   = 1'b1;
        wr_data = txd;
        @(negedge clk);
        wr_en = 1'b0;
        check("R5", "select low after accept", {31'd0, spi_cs_n}, 32'd0);
        check("R6", "busy after accept", {31'd0, busy}, 32'd1);
        if (pending_done) begin
            check("R7", "done cleared by write", {31'd0, done}, 32'd0);
            pending_done = 1'b0;
        end
        if (do_coll) begin
            repeat (3) @(negedge clk);
            wr_en   = 1'b1;
            wr_data = ~txd;
            @(negedge clk);
            wr_en = 1'b0;
            check("R8", "collision set", {31'd0, collision}, 32'd1);
        end
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check("R7", "done raised", {31'd0, done}, 32'd1);
        check("R6", "busy low at done", {31'd0, busy}, 32'd0);
        check("R3", "slave received", sl_rx & mask, txd & mask);
        check("R4", "rd_data", rd_data, sld & mask);
        check("R2", "sck transitions", 32'(sl_edges), 32'(2 * len));
        check("R2", "sck rest after", {31'd0, spi_sck}, {31'd0, cpol});
        check("R5", "setup cycles", 32'((t_first - t_csf) / 20),
              32'(setup + div + 2));
        check("R6", "hold cycles", 32'((t_csr - t_last) / 20), 32'(hold + 1));
        if (skip_rd) begin
            pending_done = 1'b1;
        end else begin
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            check("R7", "done cleared by read", {31'd0, done}, 32'd0);
        end
        if (do_coll) begin
            @(negedge clk);
            check("R9", "collision sticky", {31'd0, collision}, 32'd1);
            clr_coll = 1'b1;
            @(negedge clk);
            clr_coll = 1'b0;
            check("R9", "collision cleared", {31'd0, collision}, 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset cs_n", {31'd0, spi_cs_n}, 32'd1);
        check("R1", "reset sck", {31'd0, spi_sck}, 32'd0);
        check("R1", "reset busy", {31'd0, busy}, 32'd0);
        check("R1", "reset done", {31'd0, done}, 32'd0);
        check("R1", "reset collision", {31'd0, collision}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        clr_coll = 1'b1;
        @(negedge clk);
        clr_coll = 1'b0;
        check("R9", "clear with no collision", {31'd0, collision}, 32'd0);
        begin
            int idx;
            int lens[7];
            int divs[3];
            lens = '{2, 3, 7, 8, 16, 31, 32};
            divs = '{0, 1, 3};
            idx = 0;
            for (int m = 0; m < 4; m++) begin
                for (int li = 0; li < 7; li++) begin
                    for (int di = 0; di < 3; di++) begin
                        logic [31:0] txd, sld;
                        txd = 32'hA5C3_0F96 ^ (32'(idx) * 32'h9E37_79B9);
                        sld = {txd[12:0], txd[31:13]} ^ 32'h3C5A_96E1;
                        run(m[1], m[0], lens[li], divs[di], idx % 4,
                            (idx % 3) * 2, txd, sld,
                            (idx % 5) == 0, (idx % 6) == 2);
                        idx++;
                    end
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule